// File: doc/BRIEF.md
# ROM Patch Address Comparator Unit

This block sits between a processor's instruction fetch port and a mask ROM. Every fetch is forwarded to the ROM in the same cycle. One cycle later the ROM word comes back, and the block returns either that word or a 32-bit replacement word. The replacement is used when the fetch address matched one of eight comparator slots. Each slot pairs a 16-bit word-address compare value with a 32-bit replacement word. The slots sit in flip-flops inside the block, not in system RAM.

A configuration loader fills the slots at boot from one-time fuse data, then pulses a lock input. The same cycle as the lock pulse, the loader reports whether the fuse data passed its integrity check. Slots become active only after a lock with a passing check. A rejected configuration leaves every slot inactive. Once locked, the slot store cannot be rewritten until the next reset. This makes the unit a fixed-function code patcher for ROM bugs found after tape-out.

Top module: `rom_patch_unit`

## Requirements
- R1: With no active matching slot, `fetch_rdata_o` equals `rom_rdata_i` in the cycle after the request. `rom_req_o` and `rom_addr_o` follow `fetch_req_i` and `fetch_addr_i` combinationally.
- R2: When slots are active and fetch address bits [17:2] equal a slot's compare value, the response is that slot's replacement word instead of the ROM data.
- R3: A slot whose compare value is 16'h0000 never matches, including a fetch whose bits [17:2] are zero.
- R4: When several active slots match, the replacement word of the lowest-numbered slot is returned.
- R5: `fetch_valid_o` is high in exactly the cycle after each cycle with `fetch_req_i` high, and low otherwise. This holds for back-to-back requests.
- R6: The first cycle with `ld_lock_i` high locks the store. A write presented in that same cycle is still taken. Writes in later cycles change no slot until reset, and the lock stays set.
- R7: Substitution happens only after a lock taken with `ld_ok_i` high. Before lock, or after a lock taken with `ld_ok_i` low, every fetch returns ROM data.
- R8: Fetch address bits [1:0] and bits above 17 take no part in matching.
- R9: After reset, `fetch_valid_o` is low, the store is unlocked, and all slots hold a zero compare value.
- R10: A write with `ld_we_i` high stores `ld_cmp_i` and `ld_word_i` into the slot numbered by `ld_idx_i` (0 to 7), and leaves the other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_valid_o | output | 1 | Response valid, one cycle after request |
| fetch_rdata_o | output | 32 | Returned instruction word |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | 32 | ROM read address |
| rom_rdata_i | input | 32 | ROM data, valid the cycle after `rom_req_o` |
| ld_we_i | input | 1 | Slot write strobe |
| ld_idx_i | input | 3 | Slot number to write |
| ld_cmp_i | input | 16 | Compare value (word address bits [17:2]) |
| ld_word_i | input | 32 | Replacement word |
| ld_lock_i | input | 1 | Lock the slot store |
| ld_ok_i | input | 1 | Configuration accepted, sampled with the lock |

## Verification
The assertions assume that the ROM is synchronous. It must return valid data on `rom_rdata_i` in exactly the cycle after `rom_req_o`, with no stall. They also assume that fetch and load inputs hold known values whenever reset is released. The bench models the ROM as one registered lookup driven by `rom_addr_o`, which meets the first assumption. It changes every input only on the falling edge and holds each input at a defined value. It loads the slots so that duplicate and all-zero compare values occur. It then fetches with varied low and high address bits, both back to back and with gaps, so each priority and masking case is reached.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
  localparam int unsigned DEF_SLOTS   = 8;
  localparam int unsigned DEF_CMP_W   = 16;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_CMP_LSB = 2;
endpackage

// File: rtl/rpu_slot_bank.sv
module rpu_slot_bank #(
  parameter int unsigned N_SLOTS = rpu_pkg::DEF_SLOTS,
  parameter int unsigned CMP_W   = rpu_pkg::DEF_CMP_W,
  parameter int unsigned DATA_W  = rpu_pkg::DEF_DATA_W,
  localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [CMP_W-1:0]                cmp_i,
  input  logic [DATA_W-1:0]               word_i,
  input  logic                            lock_i,
  input  logic                            ok_i,
  output logic [N_SLOTS-1:0][CMP_W-1:0]   cmp_o,
  output logic [N_SLOTS-1:0][DATA_W-1:0]  word_o,
  output logic                            locked_o,
  output logic                            active_o
);
  logic [N_SLOTS-1:0][CMP_W-1:0]  cmp_q;
  logic [N_SLOTS-1:0][DATA_W-1:0] word_q;
  logic                           locked_q, ok_q;
  logic                           wr_open;

  // store accepts writes up to and including the lock cycle
  assign wr_open = we_i & ~locked_q;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[s]  <= '0;
        word_q[s] <= '0;
      end else if (wr_open && idx_i == IDX_W'(s)) begin
        cmp_q[s]  <= cmp_i;
        word_q[s] <= word_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      ok_q     <= 1'b0;
    end else if (lock_i && !locked_q) begin
      locked_q <= 1'b1;
      ok_q     <= ok_i;
    end
  end

  assign cmp_o    = cmp_q;
  assign word_o   = word_q;
  assign locked_o = locked_q;
  assign active_o = locked_q & ok_q;

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  assert_store_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_q) |-> ($stable(cmp_q) && $stable(word_q)));
endmodule

// File: rtl/rpu_match.sv
module rpu_match #(
  parameter int unsigned N_SLOTS = rpu_pkg::DEF_SLOTS,
  parameter int unsigned CMP_W   = rpu_pkg::DEF_CMP_W,
  parameter int unsigned DATA_W  = rpu_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W  = rpu_pkg::DEF_ADDR_W,
  parameter int unsigned CMP_LSB = rpu_pkg::DEF_CMP_LSB
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            enable_i,
  input  logic [N_SLOTS-1:0][CMP_W-1:0]   cmp_i,
  input  logic [N_SLOTS-1:0][DATA_W-1:0]  word_i,
  output logic                            hit_o,
  output logic [DATA_W-1:0]               word_o
);
  logic [CMP_W-1:0]   key;
  logic [N_SLOTS-1:0] eq, sel;

  assign key = addr_i[CMP_LSB +: CMP_W];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_cmp
    // all-zero compare value marks an unused slot
    assign eq[s] = enable_i && (cmp_i[s] != '0) && (cmp_i[s] == key);
  end

  // isolate lowest set bit: lowest slot wins
  assign sel   = eq & (~eq + {{(N_SLOTS-1){1'b0}}, 1'b1});
  assign hit_o = |eq;

  always_comb begin
    word_o = '0;
    for (int s = 0; s < N_SLOTS; s++) word_o |= {DATA_W{sel[s]}} & word_i[s];
  end

  always_comb begin
    assert_sel_onehot_R4: assert ($onehot0(sel));
  end
endmodule

// File: rtl/rpu_resp.sv
module rpu_resp #(
  parameter int unsigned DATA_W = rpu_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              req_q, hit_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hit_q  <= 1'b0;
      word_q <= '0;
    end else begin
      req_q <= req_i;
      hit_q <= req_i & hit_i;
      if (req_i && hit_i) word_q <= word_i;
    end
  end

  assign valid_o = req_q;
  assign rdata_o = hit_q ? word_q : rom_rdata_i;
endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit #(
  parameter int unsigned N_SLOTS = rpu_pkg::DEF_SLOTS,
  parameter int unsigned CMP_W   = rpu_pkg::DEF_CMP_W,
  parameter int unsigned DATA_W  = rpu_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W  = rpu_pkg::DEF_ADDR_W,
  parameter int unsigned CMP_LSB = rpu_pkg::DEF_CMP_LSB,
  localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_rdata_o,
  output logic              rom_req_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [CMP_W-1:0]  ld_cmp_i,
  input  logic [DATA_W-1:0] ld_word_i,
  input  logic              ld_lock_i,
  input  logic              ld_ok_i
);
  logic [N_SLOTS-1:0][CMP_W-1:0]  slot_cmp;
  logic [N_SLOTS-1:0][DATA_W-1:0] slot_word;
  logic                           locked, active, hit;
  logic [DATA_W-1:0]              hit_word;

  assign rom_req_o  = fetch_req_i;
  assign rom_addr_o = fetch_addr_i;

  rpu_slot_bank #(.N_SLOTS(N_SLOTS), .CMP_W(CMP_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(ld_we_i), .idx_i(ld_idx_i), .cmp_i(ld_cmp_i), .word_i(ld_word_i),
    .lock_i(ld_lock_i), .ok_i(ld_ok_i),
    .cmp_o(slot_cmp), .word_o(slot_word), .locked_o(locked), .active_o(active)
  );

  rpu_match #(.N_SLOTS(N_SLOTS), .CMP_W(CMP_W), .DATA_W(DATA_W),
              .ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_match (
    .addr_i(fetch_addr_i), .enable_i(active),
    .cmp_i(slot_cmp), .word_i(slot_word),
    .hit_o(hit), .word_o(hit_word)
  );

  rpu_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i, .rst_ni,
    .req_i(fetch_req_i), .hit_i(hit), .word_i(hit_word),
    .rom_rdata_i, .valid_o(fetch_valid_o), .rdata_o(fetch_rdata_o)
  );

  assert_valid_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (fetch_valid_o == $past(fetch_req_i)));

  assert_inactive_passes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fetch_req_i) && !$past(active)) |-> (fetch_rdata_o == rom_rdata_i));

  assert_unlocked_inactive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> !active);
endmodule

// File: tb/rom_patch_unit_bench.sv
module rom_patch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_valid;
  logic [31:0] fetch_rdata;
  logic        rom_req;
  logic [31:0] rom_addr;
  logic [31:0] rom_q = '0;
  logic        ld_we = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [15:0] ld_cmp = '0;
  logic [31:0] ld_word = '0;
  logic        ld_lock = 1'b0;
  logic        ld_ok = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] sh_cmp [NS];
  logic [31:0] sh_word [NS];
  bit sh_locked, sh_active;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_patch_unit u_rom_patch_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .fetch_valid_o(fetch_valid), .fetch_rdata_o(fetch_rdata),
    .rom_req_o(rom_req), .rom_addr_o(rom_addr), .rom_rdata_i(rom_q),
    .ld_we_i(ld_we), .ld_idx_i(ld_idx), .ld_cmp_i(ld_cmp), .ld_word_i(ld_word),
    .ld_lock_i(ld_lock), .ld_ok_i(ld_ok)
  );

  function automatic logic [31:0] rom_fn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) if (rom_req) rom_q <= rom_fn(rom_addr);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every valid response pops one expected item
  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), fetch_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] model(logic [31:0] a);
    if (sh_active)
      for (int s = 0; s < NS; s++)
        if (sh_cmp[s] != 16'h0 && sh_cmp[s] == a[17:2]) return sh_word[s];
    return rom_fn(a);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_req = 1'b0; ld_we = 1'b0; ld_lock = 1'b0;
    for (int s = 0; s < NS; s++) begin sh_cmp[s] = '0; sh_word[s] = '0; end
    sh_locked = 0; sh_active = 0;
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    check("R9 valid low in reset", {31'd0, fetch_valid}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic load(int idx, logic [15:0] c, logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = 3'(idx); ld_cmp = c; ld_word = w;
    if (!sh_locked) begin sh_cmp[idx] = c; sh_word[idx] = w; end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic lock(bit ok);
    @(negedge clk);
    ld_lock = 1'b1; ld_ok = ok;
    if (!sh_locked) begin sh_locked = 1; sh_active = ok; end
    @(negedge clk);
    ld_lock = 1'b0; ld_ok = 1'b0;
  endtask

  task automatic fetch(logic [31:0] a, string tag);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    exp_q.push_back(model(a)); tag_q.push_back(tag);
    #1;
    check("R1 rom_addr forward", rom_addr, a);
    check("R1 rom_req forward", {31'd0, rom_req}, 32'd1);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    fetch_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R9 valid low after reset", {31'd0, fetch_valid}, 32'd0);
    // R9: zero compare values after reset, seen through a passing lock
    lock(1'b1);
    fetch(32'h0000_0000, "R9 no slot after reset");
    idle(2);

    do_reset();
    // R7: before lock, loaded slots stay inactive
    load(1, 16'h0100, 32'hDEAD_BEEF);
    fetch(32'h0000_0400, "R7 pre-lock pass");
    idle(2);
    load(0, 16'h0000, 32'h0BAD_0BAD);
    load(2, 16'h0100, 32'hCAFE_F00D);
    load(3, 16'h0200, 32'h1234_5678);
    load(7, 16'hFFFF, 32'h7777_0007);
    lock(1'b1);
    fetch(32'h0000_0400, "R2 R4 slot1 over slot2");
    fetch(32'h0000_0800, "R2 R10 slot3");
    fetch(32'h0003_FFFC, "R10 slot7");
    fetch(32'h0000_0000, "R3 zero cmp no hit");
    fetch(32'h0000_0403, "R8 low bits ignored");
    fetch(32'h0004_0402, "R8 high bits ignored");
    fetch(32'h0000_1234, "R1 miss pass");
    idle(1);
    fetch(32'h0000_0804, "R1 neighbour miss");
    fetch(32'hFFFF_FFFF, "R8 slot7 all ones addr");
    idle(2);
    // R6: writes after lock ignored
    load(1, 16'h0300, 32'h1111_1111);
    load(4, 16'h0200, 32'h4444_4444);
    fetch(32'h0000_0400, "R6 slot1 unchanged");
    fetch(32'h0000_0C00, "R6 new cmp ignored");
    fetch(32'h0000_0800, "R6 R4 slot3 kept");
    idle(2);

    do_reset();
    fetch(32'h0000_0400, "R9 slots cleared");
    idle(1);
    load(4, 16'h0100, 32'h4040_4040);
    lock(1'b0);
    fetch(32'h0000_0400, "R7 rejected config pass");
    idle(1);
    lock(1'b1);
    fetch(32'h0000_0400, "R6 R7 relock ignored");
    idle(2);

    do_reset();
    // R6: write in the lock cycle itself is taken
    @(negedge clk);
    ld_we = 1'b1; ld_idx = 3'd5; ld_cmp = 16'h0010; ld_word = 32'h5555_AAAA;
    ld_lock = 1'b1; ld_ok = 1'b1;
    sh_cmp[5] = 16'h0010; sh_word[5] = 32'h5555_AAAA; sh_locked = 1; sh_active = 1;
    @(negedge clk);
    ld_we = 1'b0; ld_lock = 1'b0; ld_ok = 1'b0;
    fetch(32'h0000_0040, "R6 lock-cycle write taken");
    fetch(32'h0000_0044, "R1 miss after");
    idle(3);

    check("R5 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule